// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block is the front end of a device command mailbox. The host writes a command word and then sets a doorbell. While the doorbell is up, the block owns the command word. It looks up the 16-bit opcode in a parameterised table of supported commands and checks the supplied payload length against the entry's expected length. If the command is acceptable, it starts the matching handler through a one-cycle start pulse and waits for that handler's done pulse.

Unknown opcodes and length mismatches are answered directly with a fixed return code, and no handler ever sees them. The same applies to any other rejection the block makes itself.

Once a result exists, the block writes it back in a fixed order. First it rebuilds the status register from the return code and rewrites the command register with zeroed opcode fields and the output length. One cycle later it drops the doorbell. Payload storage and the handlers themselves live outside the block; it only presents the selected opcode, table index, input length and effect bits to them.

Top module: `mbox_dispatch`

## Requirements
- R1: The command register holds the command in bits [7:0], the command set in bits [15:8] and the payload length in bits [31:16]. A host write while idle stores the word as given. The opcode matched against the table is {set, command}, so set 0x00 with command 0x01 is opcode 0x0001, which differs from set 0x01 with command 0x00 (opcode 0x0100).
- R2: An opcode not present in the table completes with return code 0x03 and output length 0, and no handler start pulse is issued.
- R3: A fixed-length entry whose expected length differs from the supplied length completes with return code 0x16 and output length 0, and no handler start pulse is issued.
- R4: An entry flagged as variable-length accepts any supplied length, including 0 and 0x123, and starts its handler.
- R5: An accepted command produces exactly one single-cycle hnd_start pulse, issued while the doorbell is set. During the pulse the outputs hnd_opcode, hnd_in_len and hnd_effect carry the command's opcode, its input length and the entry's effect bits.
- R6: On completion, command register bits [15:0] read 0 and bits [31:16] read the handler's output length. The status register reads the handler's return code in bits [4:0], with bits [15:5] zero.
- R7: A handler output length above PAYLOAD_BYTES (default 256) is reported as PAYLOAD_BYTES, and the return code becomes 0x04. A length exactly equal to PAYLOAD_BYTES passes unchanged with the handler's code.
- R8: The doorbell reads 1 from the cycle after a doorbell write until completion. The command and status registers already hold their final values in the last cycle that the doorbell reads 1, and the doorbell clears one cycle after they are written.
- R9: Doorbell writes and command register writes made while a dispatch is in progress are ignored. They cause no second handler start and do not change the command register.
- R10: After reset the doorbell, command register, status register and hnd_start all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 32 | Command register write data {length, set, command} |
| db_set | input | 1 | Host write setting the doorbell |
| cmd_reg | output | 32 | Command register readback |
| sts_reg | output | 16 | Status register readback, return code in [4:0] |
| doorbell | output | 1 | Doorbell bit, cleared by the block on completion |
| hnd_start | output | 1 | One-cycle handler start pulse |
| hnd_index | output | IDX_W | Table index of the selected entry |
| hnd_opcode | output | 16 | Opcode being dispatched |
| hnd_in_len | output | 16 | Supplied input payload length |
| hnd_effect | output | 8 | Effect bits of the selected entry |
| hnd_done | input | 1 | Handler completion pulse |
| hnd_out_len | input | 16 | Handler output length, valid with hnd_done |
| hnd_rc | input | 5 | Handler return code, valid with hnd_done |

## Verification
The main function is driven through a vector table whose rows fall into five groups:
- opcodes absent from the table, including the byte-swapped twin of a real opcode, which shows whether set and command land in the right bytes;
- fixed-length entries given the exact length and a wrong length, which separates the length check from the lookup;
- variable-length entries given zero and odd lengths;
- handler responses with non-zero return codes, which show the handler's code is passed through rather than replaced;
- output lengths just at and just above the buffer size, which pin the clamp threshold.

Directed tests then check the reset state and command readback. They also fire doorbell and command writes in the middle of a running dispatch, to show that neither a second start nor a changed command word results.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int LEN_W  = 16;
   localparam int OP_W   = 16;
   localparam int EFF_W  = 8;
   localparam int RC_W   = 5;
   localparam int STS_W  = 16;
   localparam int CMD_W  = LEN_W + OP_W;

   localparam logic [RC_W-1:0] RC_OK      = 5'h00;
   localparam logic [RC_W-1:0] RC_BAD_IN  = 5'h02;
   localparam logic [RC_W-1:0] RC_NO_CMD  = 5'h03;
   localparam logic [RC_W-1:0] RC_FAULT   = 5'h04;
   localparam logic [RC_W-1:0] RC_BAD_LEN = 5'h16;

   typedef struct packed {
      logic [OP_W-1:0]  opcode;
      logic [LEN_W-1:0] in_len;
      logic             var_len;
      logic [EFF_W-1:0] effect;
   } op_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOOKUP, ST_RUN, ST_WB, ST_CLR
   } seq_st_e;

   localparam int DEF_NUM_OPS = 8;
   typedef op_entry_t [DEF_NUM_OPS-1:0] def_tbl_t;

   function automatic op_entry_t mk_entry(input logic [OP_W-1:0] op,
                                          input logic [LEN_W-1:0] len,
                                          input logic vl,
                                          input logic [EFF_W-1:0] eff);
      op_entry_t e;
      e.opcode  = op;
      e.in_len  = len;
      e.var_len = vl;
      e.effect  = eff;
      return e;
   endfunction

   function automatic def_tbl_t build_def_table();
      def_tbl_t t;
      t[0] = mk_entry(16'h0100, 16'h0001, 1'b0, 8'h00);
      t[1] = mk_entry(16'h0101, 16'h0000, 1'b1, 8'h10);
      t[2] = mk_entry(16'h0103, 16'h0004, 1'b0, 8'h02);
      t[3] = mk_entry(16'h0300, 16'h0000, 1'b0, 8'h00);
      t[4] = mk_entry(16'h0301, 16'h0008, 1'b0, 8'h08);
      t[5] = mk_entry(16'h0401, 16'h0018, 1'b0, 8'h00);
      t[6] = mk_entry(16'h4100, 16'h0000, 1'b0, 8'h00);
      t[7] = mk_entry(16'h4103, 16'h0000, 1'b1, 8'h06);
      return t;
   endfunction

   localparam def_tbl_t DEF_TABLE = build_def_table();

endpackage

// File: rtl/mbox_lookup.sv
module mbox_lookup
   import mbox_pkg::*;
#(
   parameter int NUM_OPS = DEF_NUM_OPS,
   parameter op_entry_t [NUM_OPS-1:0] OP_TABLE = DEF_TABLE,
   parameter int IDX_W = 3
)(
   input  logic [OP_W-1:0]  opcode,
   input  logic [LEN_W-1:0] in_len,
   output logic             hit,
   output logic             len_ok,
   output logic [IDX_W-1:0] idx,
   output logic [EFF_W-1:0] effect
);

   logic [NUM_OPS-1:0] match;
   op_entry_t          sel;

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
      assign match[i] = (OP_TABLE[i].opcode == opcode);
   end

   // lowest matching index wins
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_OPS - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign sel    = OP_TABLE[idx];
   assign len_ok = sel.var_len || (sel.in_len == in_len);
   assign effect = sel.effect;

endmodule

// File: rtl/mbox_clamp.sv
module mbox_clamp
   import mbox_pkg::*;
#(
   parameter int PAYLOAD_BYTES = 256
)(
   input  logic [LEN_W-1:0] raw_len,
   input  logic [RC_W-1:0]  raw_rc,
   output logic [LEN_W-1:0] len,
   output logic [RC_W-1:0]  rc
);

   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(PAYLOAD_BYTES);

   logic over;

   assign over = (raw_len > MAX_LEN);
   assign len  = over ? MAX_LEN  : raw_len;
   assign rc   = over ? RC_FAULT : raw_rc;

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
   import mbox_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             db_set,
   input  logic             hit,
   input  logic             len_ok,
   input  logic             done,
   input  logic [LEN_W-1:0] res_len_in,
   input  logic [RC_W-1:0]  res_rc_in,
   output logic [CMD_W-1:0] cmd_reg,
   output logic [STS_W-1:0] sts_reg,
   output logic             doorbell,
   output logic             start
);

   seq_st_e          st;
   logic [LEN_W-1:0] res_len;
   logic [RC_W-1:0]  res_rc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cmd_reg  <= '0;
         sts_reg  <= '0;
         doorbell <= 1'b0;
         start    <= 1'b0;
         res_len  <= '0;
         res_rc   <= '0;
      end else begin
         start <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (cmd_wr) cmd_reg <= cmd_wdata;
               if (db_set) begin
                  doorbell <= 1'b1;
                  st       <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (!hit) begin
                  res_rc  <= RC_NO_CMD;
                  res_len <= '0;
                  st      <= ST_WB;
               end else if (!len_ok) begin
                  res_rc  <= RC_BAD_LEN;
                  res_len <= '0;
                  st      <= ST_WB;
               end else begin
                  start <= 1'b1;
                  st    <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (done) begin
                  res_len <= res_len_in;
                  res_rc  <= res_rc_in;
                  st      <= ST_WB;
               end
            end
            ST_WB: begin
               cmd_reg <= {res_len, {OP_W{1'b0}}};
               sts_reg <= {{(STS_W-RC_W){1'b0}}, res_rc};
               st      <= ST_CLR;
            end
            ST_CLR: begin
               doorbell <= 1'b0;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch
   import mbox_pkg::*;
#(
   parameter int NUM_OPS = DEF_NUM_OPS,
   parameter op_entry_t [NUM_OPS-1:0] OP_TABLE = DEF_TABLE,
   parameter int PAYLOAD_BYTES = 256,
   localparam int IDX_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             db_set,
   output logic [CMD_W-1:0] cmd_reg,
   output logic [STS_W-1:0] sts_reg,
   output logic             doorbell,
   output logic             hnd_start,
   output logic [IDX_W-1:0] hnd_index,
   output logic [OP_W-1:0]  hnd_opcode,
   output logic [LEN_W-1:0] hnd_in_len,
   output logic [EFF_W-1:0] hnd_effect,
   input  logic             hnd_done,
   input  logic [LEN_W-1:0] hnd_out_len,
   input  logic [RC_W-1:0]  hnd_rc
);

   if (NUM_OPS < 1) begin : g_bad_ops
      $error("NUM_OPS must be at least 1");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES >= (1 << LEN_W)) begin : g_bad_pl
      $error("PAYLOAD_BYTES must fit the length field");
   end

   logic             hit;
   logic             len_ok;
   logic [LEN_W-1:0] cl_len;
   logic [RC_W-1:0]  cl_rc;

   assign hnd_opcode = cmd_reg[OP_W-1:0];
   assign hnd_in_len = cmd_reg[CMD_W-1:OP_W];

   mbox_lookup #(
      .NUM_OPS (NUM_OPS),
      .OP_TABLE(OP_TABLE),
      .IDX_W   (IDX_W)
   ) u_lookup (
      .opcode(hnd_opcode),
      .in_len(hnd_in_len),
      .hit   (hit),
      .len_ok(len_ok),
      .idx   (hnd_index),
      .effect(hnd_effect)
   );

   mbox_clamp #(
      .PAYLOAD_BYTES(PAYLOAD_BYTES)
   ) u_clamp (
      .raw_len(hnd_out_len),
      .raw_rc (hnd_rc),
      .len    (cl_len),
      .rc     (cl_rc)
   );

   mbox_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_wdata (cmd_wdata),
      .db_set    (db_set),
      .hit       (hit),
      .len_ok    (len_ok),
      .done      (hnd_done),
      .res_len_in(cl_len),
      .res_rc_in (cl_rc),
      .cmd_reg   (cmd_reg),
      .sts_reg   (sts_reg),
      .doorbell  (doorbell),
      .start     (hnd_start)
   );

endmodule

// File: rtl/mbox_dispatch_chk.sv
module mbox_dispatch_chk #(
   parameter int PAYLOAD_BYTES = 256
)(
   input logic        clk,
   input logic        rst_n,
   input logic        doorbell,
   input logic [31:0] cmd_reg,
   input logic [15:0] sts_reg,
   input logic        hnd_start
);

   assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |=> !hnd_start);

   assert_start_under_bell_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |-> (doorbell && $past(doorbell)));

   assert_regs_before_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> ($stable(cmd_reg) && $stable(sts_reg)));

   assert_opcode_zeroed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> (cmd_reg[15:0] == 16'h0000));

   assert_status_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> (sts_reg[15:5] == 11'h000));

   assert_len_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> (cmd_reg[31:16] <= 16'(PAYLOAD_BYTES)));

endmodule

bind mbox_dispatch mbox_dispatch_chk #(
   .PAYLOAD_BYTES(PAYLOAD_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .doorbell (doorbell),
   .cmd_reg  (cmd_reg),
   .sts_reg  (sts_reg),
   .hnd_start(hnd_start)
);

// File: tb/sim_mbox_dispatch.sv
module sim_mbox_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic        db_set = 1'b0;
   logic [31:0] cmd_reg;
   logic [15:0] sts_reg;
   logic        doorbell;
   logic        hnd_start;
   logic [2:0]  hnd_index;
   logic [15:0] hnd_opcode;
   logic [15:0] hnd_in_len;
   logic [7:0]  hnd_effect;
   logic        hnd_done = 1'b0;
   logic [15:0] hnd_out_len = '0;
   logic [4:0]  hnd_rc = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mbox_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .db_set(db_set), .cmd_reg(cmd_reg), .sts_reg(sts_reg),
      .doorbell(doorbell), .hnd_start(hnd_start), .hnd_index(hnd_index),
      .hnd_opcode(hnd_opcode), .hnd_in_len(hnd_in_len),
      .hnd_effect(hnd_effect), .hnd_done(hnd_done),
      .hnd_out_len(hnd_out_len), .hnd_rc(hnd_rc)
   );

   typedef struct packed {
      logic [7:0]  set;
      logic [7:0]  code;
      logic [15:0] len;
      logic        start;
      logic [15:0] olen;
      logic [4:0]  hrc;
      logic [15:0] elen;
      logic [4:0]  erc;
      logic [7:0]  eff;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'h01, 8'h00, 16'h0001, 1'b1, 16'h0020, 5'h00, 16'h0020, 5'h00, 8'h00},
      '{8'h01, 8'h00, 16'h0002, 1'b0, 16'h0000, 5'h00, 16'h0000, 5'h16, 8'h00},
      '{8'h02, 8'h00, 16'h0000, 1'b0, 16'h0000, 5'h00, 16'h0000, 5'h03, 8'h00},
      '{8'h01, 8'h01, 16'h0123, 1'b1, 16'h0000, 5'h00, 16'h0000, 5'h00, 8'h10},
      '{8'h41, 8'h03, 16'h0000, 1'b1, 16'h0004, 5'h00, 16'h0004, 5'h00, 8'h06},
      '{8'h04, 8'h01, 16'h0018, 1'b1, 16'h0040, 5'h02, 16'h0040, 5'h02, 8'h00},
      '{8'h03, 8'h01, 16'h0008, 1'b1, 16'h0000, 5'h00, 16'h0000, 5'h00, 8'h08},
      '{8'h41, 8'h00, 16'h0000, 1'b1, 16'h0100, 5'h00, 16'h0100, 5'h00, 8'h00},
      '{8'h41, 8'h00, 16'h0000, 1'b1, 16'h0101, 5'h00, 16'h0100, 5'h04, 8'h00},
      '{8'h00, 8'h01, 16'h0000, 1'b0, 16'h0000, 5'h00, 16'h0000, 5'h03, 8'h00},
      '{8'h03, 8'h00, 16'h0001, 1'b0, 16'h0000, 5'h00, 16'h0000, 5'h16, 8'h00}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one full dispatch; poke = inject busy-time writes
   task automatic dispatch(input logic [7:0] s, input logic [7:0] c,
                           input logic [15:0] l, input logic [15:0] olen,
                           input logic [4:0] hrc, input bit poke,
                           output int starts, output logic [15:0] op,
                           output logic [15:0] ilen, output logic [7:0] eff,
                           output logic [15:0] last_sts);
      int cnt = 0;
      int n = 0;
      starts = 0; op = '0; ilen = '0; eff = '0; last_sts = '0;
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = {l, s, c};
      @(negedge clk); cmd_wr = 1'b0; db_set = 1'b1;
      @(negedge clk); db_set = 1'b0;
      while (doorbell && n < 200) begin
         last_sts = sts_reg;
         if (hnd_start) begin
            starts++;
            op = hnd_opcode; ilen = hnd_in_len; eff = hnd_effect;
            cnt = 1;
         end else if (cnt != 0) begin
            cnt++;
         end
         if (poke && cnt == 1) begin
            cmd_wr = 1'b1; cmd_wdata = 32'h0005_0200; db_set = 1'b1;
         end else begin
            cmd_wr = 1'b0; db_set = 1'b0;
         end
         hnd_done = (cnt == 3);
         hnd_out_len = olen;
         hnd_rc = hrc;
         @(negedge clk);
         n++;
      end
      hnd_done = 1'b0; cmd_wr = 1'b0; db_set = 1'b0;
      if (n >= 200) check("R8", "dispatch timeout", 32'd1, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int starts;
      logic [15:0] op, ilen, last_sts;
      logic [7:0] eff;

      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "doorbell", {31'd0, doorbell}, 32'd0);
      check("R10", "cmd_reg", cmd_reg, 32'd0);
      check("R10", "sts_reg", {16'd0, sts_reg}, 32'd0);
      check("R10", "hnd_start", {31'd0, hnd_start}, 32'd0);
      rst_n = 1'b1;

      // R1 readback of stored command word
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 32'hBEEF_4103;
      @(negedge clk); cmd_wr = 1'b0;
      check("R1", "cmd readback", cmd_reg, 32'hBEEF_4103);

      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         dispatch(v.set, v.code, v.len, v.olen, v.hrc, 1'b0,
                  starts, op, ilen, eff, last_sts);
         // R2/R3/R4/R5: start issued only when accepted
         check(v.start ? "R4" : "R2/R3", $sformatf("vec%0d starts", i),
               starts, v.start ? 32'd1 : 32'd0);
         if (v.start) begin
            check("R5", $sformatf("vec%0d opcode", i), {16'd0, op}, {16'd0, v.set, v.code});
            check("R5", $sformatf("vec%0d in_len", i), {16'd0, ilen}, {16'd0, v.len});
            check("R5", $sformatf("vec%0d effect", i), {24'd0, eff}, {24'd0, v.eff});
         end
         // R6/R7 final registers
         check("R6", $sformatf("vec%0d cmd_reg", i), cmd_reg, {v.elen, 16'h0000});
         check("R6", $sformatf("vec%0d sts_reg", i), {16'd0, sts_reg}, {27'd0, v.erc});
         // R8 status final before doorbell drop
         check("R8", $sformatf("vec%0d sts before clear", i), {16'd0, last_sts}, {27'd0, v.erc});
      end

      // R9 busy writes ignored
      dispatch(8'h01, 8'h00, 16'h0001, 16'h0011, 5'h00, 1'b1,
               starts, op, ilen, eff, last_sts);
      check("R9", "single start under busy writes", starts, 32'd1);
      check("R9", "cmd_reg unaltered by busy write", cmd_reg, 32'h0011_0000);
      starts = 0;
      repeat (6) begin
         @(negedge clk);
         if (hnd_start) starts++;
         if (doorbell) starts += 100;
      end
      check("R9", "no dispatch after busy doorbell", starts, 32'd0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule